// File: doc/BRIEF.md
# Readout Record Framer

The framer turns pending readout items into a continuous byte stream for a downstream 8b10b encoder. It emits one byte per clock, together with a flag that marks the byte as a control character. Every payload item is a 24-bit record and leaves the framer as three bytes, most significant first. There are four sources, each with its own valid/ready handshake:

- event headers,
- hit-pair records,
- register read-back items,
- service messages.

An event goes out as a frame. The frame opens with a start comma and the event header, carries the hit records of that event, and closes with an end comma. Read-back address/value pairs travel outside frames. A service message may ride inside a frame, at most once per frame, or go out on its own between frames. Whenever nothing is due, the framer sends the idle comma.

When encoding is switched off, no control character is produced. Every comma slot becomes a 3-byte empty record made of a programmable fill byte, so a receiver without a decoder still sees whole 24-bit words. The byte clock is the framer clock. Each unit is either one comma or one 3-byte record, and a unit is chosen only at the boundary where the previous unit ends.

Top module: `rec_framer`

## Requirements
- R1: After reset, and whenever nothing is pending, the output is the idle comma: byte 0x3C with the control flag high. No ready is asserted unless its valid is high.
- R2: Each record leaves as three consecutive bytes, bits 23:16 first and bits 7:0 last, with the control flag low.
- R3: An accepted header produces, in this order:
  - the start comma, 0xFC with the flag high;
  - the header record {11101, 001, 0000, trigger[3:0], bcid[7:0]};
  - the hit records of the event;
  - the end comma, 0xBC with the flag high.
  The end comma follows the hit marked last, or follows the header directly when the header is flagged as having no hits. While a frame waits for a hit, idle commas fill the gap.
- R4: A hit record is {column[6:0], row[8:0], top ToT[3:0], bottom ToT[3:0]}.
- R5: A read-back item with the value-only bit low emits the address record {11101, 010, type, address[14:0]} and, with no byte between them, the value record {11101, 100, value[15:0]}. With the value-only bit high, only the value record is emitted. Read-back items are taken only outside frames.
- R6: A service record is {11101, 111, message[15:0]}. A frame carries at most one of them. A further service message waits until after the end comma and then goes out on its own.
- R7: Outside a frame, at a unit boundary, a pending header wins over a pending read-back item, and a read-back item wins over a standalone service message. Frames never interleave with read-back records.
- R8: A start comma is always followed directly by the header's first byte (0xE9), so 0xFC with the flag high never appears twice in a row.
- R9: With encoding off, the control flag is never high, and every comma slot is replaced by three fill bytes. A change of the encoding input takes effect at the next unit boundary.
- R10: Each accepted item raises exactly one ready for one cycle, and at most one ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_en | input | 1 | 1: commas with control flag; 0: fill-byte empty records |
| fill_byte | input | 8 | Byte used for empty records when encoding is off |
| hdr_valid | input | 1 | Event header pending |
| hdr_ready | output | 1 | Header accepted this cycle |
| hdr_trig | input | 4 | Trigger number of the event |
| hdr_bcid | input | 8 | Bunch-crossing number of the event |
| hdr_nohit | input | 1 | Event has no hit records |
| hit_valid | input | 1 | Hit record pending |
| hit_ready | output | 1 | Hit accepted this cycle |
| hit_col | input | 7 | Column of the pixel pair |
| hit_row | input | 9 | Row of the pixel pair |
| hit_tot_top | input | 4 | Charge of the upper pixel |
| hit_tot_bot | input | 4 | Charge of the lower pixel |
| hit_last | input | 1 | Last hit of the event |
| rb_valid | input | 1 | Read-back item pending |
| rb_ready | output | 1 | Read-back item accepted this cycle |
| rb_vonly | input | 1 | Emit the value record only |
| rb_type | input | 1 | 0 global register, 1 shift-register position |
| rb_addr | input | 15 | Read-back address |
| rb_value | input | 16 | Read-back value |
| svc_valid | input | 1 | Service message pending |
| svc_ready | output | 1 | Service message accepted this cycle |
| svc_msg | input | 16 | Service message |
| out_byte | output | 8 | Stream byte |
| out_k | output | 1 | Byte is a control character |

## Verification
The bench targets the following corner cases:

- **Empty event.** A framer that always waits for a hit would never close the frame and would hang after the header.
- **Header and read-back arriving together.** Wrong priority would put address/value pairs ahead of the frame. A framer without the frame lock would slip them between hit records.
- **Two service messages during one frame.** A framer without a per-frame limit would put both inside the frame instead of sending the second after the end comma.
- **Value records.** A broken pending path would insert idle commas between the address and value records, or would emit a lone address record.
- **Bypass mode.** A framer that still flags commas would leak the control flag. One that sends single fill bytes would break the 24-bit word alignment, which shows up as stray fill bytes where records are expected.

// File: rtl/rec_framer.sv
module rec_framer #(
  parameter logic [7:0] K_SOF  = 8'hFC,
  parameter logic [7:0] K_EOF  = 8'hBC,
  parameter logic [7:0] K_IDLE = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enc_en,
  input  logic [7:0]  fill_byte,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic [3:0]  hdr_trig,
  input  logic [7:0]  hdr_bcid,
  input  logic        hdr_nohit,
  input  logic        hit_valid,
  output logic        hit_ready,
  input  logic [6:0]  hit_col,
  input  logic [8:0]  hit_row,
  input  logic [3:0]  hit_tot_top,
  input  logic [3:0]  hit_tot_bot,
  input  logic        hit_last,
  input  logic        rb_valid,
  output logic        rb_ready,
  input  logic        rb_vonly,
  input  logic        rb_type,
  input  logic [14:0] rb_addr,
  input  logic [15:0] rb_value,
  input  logic        svc_valid,
  output logic        svc_ready,
  input  logic [15:0] svc_msg,
  output logic [7:0]  out_byte,
  output logic        out_k
);
  localparam logic [4:0] MARK  = 5'b11101;
  localparam logic [2:0] T_HDR = 3'b001;
  localparam logic [2:0] T_ADR = 3'b010;
  localparam logic [2:0] T_VAL = 3'b100;
  localparam logic [2:0] T_SVC = 3'b111;

  logic        is_comma, unit_enc, in_frame, svc_used, frame_done, pend;
  logic [1:0]  idx;
  logic [7:0]  ccode;
  logic [23:0] rec, pend_rec;

  logic        n_comma, n_pend, n_in_frame, n_svc_used, n_done;
  logic [7:0]  n_code;
  logic [23:0] n_rec, n_pend_rec;

  wire bnd = (is_comma && unit_enc) || (idx == 2'd2);
  wire [23:0] val_rec = {MARK, T_VAL, rb_value};

  always_comb begin
    hdr_ready = 1'b0; hit_ready = 1'b0; rb_ready = 1'b0; svc_ready = 1'b0;
    n_comma = 1'b1; n_code = K_IDLE; n_rec = rec;
    n_pend = 1'b0; n_pend_rec = pend_rec;
    n_in_frame = in_frame; n_svc_used = svc_used; n_done = frame_done;
    if (bnd) begin
      if (pend) begin
        n_comma = 1'b0;
        n_rec = pend_rec;
      end else if (in_frame) begin
        if (svc_valid && !svc_used) begin
          svc_ready = 1'b1; n_comma = 1'b0;
          n_rec = {MARK, T_SVC, svc_msg};
          n_svc_used = 1'b1;
        end else if (frame_done) begin
          n_code = K_EOF;
          n_in_frame = 1'b0;
        end else if (hit_valid) begin
          hit_ready = 1'b1; n_comma = 1'b0;
          n_rec = {hit_col, hit_row, hit_tot_top, hit_tot_bot};
          n_done = hit_last;
        end
      end else if (hdr_valid) begin
        hdr_ready = 1'b1;
        n_code = K_SOF;
        n_pend = 1'b1;
        n_pend_rec = {MARK, T_HDR, 4'b0000, hdr_trig, hdr_bcid};
        n_in_frame = 1'b1; n_svc_used = 1'b0; n_done = hdr_nohit;
      end else if (rb_valid) begin
        rb_ready = 1'b1; n_comma = 1'b0;
        if (rb_vonly) begin
          n_rec = val_rec;
        end else begin
          n_rec = {MARK, T_ADR, rb_type, rb_addr};
          n_pend = 1'b1;
          n_pend_rec = val_rec;
        end
      end else if (svc_valid) begin
        svc_ready = 1'b1; n_comma = 1'b0;
        n_rec = {MARK, T_SVC, svc_msg};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_comma <= 1'b1; ccode <= K_IDLE; unit_enc <= 1'b1; idx <= 2'd0;
      rec <= '0; pend <= 1'b0; pend_rec <= '0;
      in_frame <= 1'b0; svc_used <= 1'b0; frame_done <= 1'b0;
    end else if (bnd) begin
      is_comma <= n_comma; ccode <= n_code; unit_enc <= enc_en; idx <= 2'd0;
      rec <= n_rec; pend <= n_pend; pend_rec <= n_pend_rec;
      in_frame <= n_in_frame; svc_used <= n_svc_used; frame_done <= n_done;
    end else begin
      idx <= idx + 2'd1;
    end
  end

  assign out_k = is_comma && unit_enc;
  always_comb begin
    if (is_comma)          out_byte = unit_enc ? ccode : fill_byte;
    else if (idx == 2'd0)  out_byte = rec[23:16];
    else if (idx == 2'd1)  out_byte = rec[15:8];
    else                   out_byte = rec[7:0];
  end
endmodule

// File: rtl/rec_framer_chk.sv
module rec_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic        hit_valid,
  input logic        hit_ready,
  input logic [6:0]  hit_col,
  input logic [8:0]  hit_row,
  input logic        rb_valid,
  input logic        rb_ready,
  input logic        rb_vonly,
  input logic        svc_valid,
  input logic        svc_ready,
  input logic [7:0]  out_byte,
  input logic        out_k
);
  // R8
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k && out_byte == 8'hFC) |=> !(out_k && out_byte == 8'hFC));
  // R8
  sof_then_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k && out_byte == 8'hFC) |=> (!out_k && out_byte == 8'hE9));
  // R1
  k_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_k |-> (out_byte == 8'hFC || out_byte == 8'hBC || out_byte == 8'h3C));
  // R10
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_ready || hdr_valid) && (!hit_ready || hit_valid) &&
    (!rb_ready || rb_valid) && (!svc_ready || svc_valid));
  // R10
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_ready, hit_ready, rb_ready, svc_ready}));
  // R4
  hit_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |=> (!out_k && out_byte == {$past(hit_col), $past(hit_row[8])}));
  // R5
  ar_vr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_ready && !rb_vonly) |-> ##4 (!out_k && out_byte == 8'hEC));
  // R6
  svc_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ready |=> (!out_k && out_byte == 8'hEF));
endmodule

bind rec_framer rec_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_col(hit_col), .hit_row(hit_row),
  .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_vonly(rb_vonly),
  .svc_valid(svc_valid), .svc_ready(svc_ready), .out_byte(out_byte), .out_k(out_k)
);

// File: tb/rec_framer_tb.sv
module rec_framer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_en = 1'b1;
  logic [7:0] fill_byte = 8'hA5;
  logic hdr_valid = 0, hdr_nohit = 0; logic [3:0] hdr_trig = 0; logic [7:0] hdr_bcid = 0;
  logic hit_valid = 0, hit_last = 0; logic [6:0] hit_col = 0; logic [8:0] hit_row = 0;
  logic [3:0] hit_tot_top = 0, hit_tot_bot = 0;
  logic rb_valid = 0, rb_vonly = 0, rb_type = 0; logic [14:0] rb_addr = 0; logic [15:0] rb_value = 0;
  logic svc_valid = 0; logic [15:0] svc_msg = 0;
  logic hdr_ready, hit_ready, rb_ready, svc_ready, out_k;
  logic [7:0] out_byte;

  always #2 clk = ~clk;

  rec_framer u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  bit log_on = 0;
  int log_n = 0;
  logic [7:0] lb [0:1023];
  logic       lk [0:1023];
  int exp_n = 0;
  logic [7:0] eb [0:255];
  logic       ek [0:255];

  always @(negedge clk) if (log_on && log_n < 1024) begin
    lb[log_n] = out_byte; lk[log_n] = out_k; log_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_k(input logic [7:0] b);
    eb[exp_n] = b; ek[exp_n] = 1'b1; exp_n++;
  endtask
  task automatic push_rec(input logic [23:0] r);
    eb[exp_n] = r[23:16]; ek[exp_n] = 0; eb[exp_n+1] = r[15:8]; ek[exp_n+1] = 0;
    eb[exp_n+2] = r[7:0]; ek[exp_n+2] = 0; exp_n += 3;
  endtask

  task automatic start_log; log_n = 0; exp_n = 0; log_on = 1; endtask

  // compare log with idle units removed against expected stream
  task automatic compare(input string req, input bit bypass);
    int n = 0;
    logic [7:0] fb [0:1023];
    logic       fk [0:1023];
    repeat (24) @(negedge clk);
    log_on = 0;
    for (int i = 0; i < log_n; i++) begin
      if (!bypass && lk[i] && lb[i] == 8'h3C) continue;
      if (bypass && !lk[i] && lb[i] == fill_byte) continue;
      fb[n] = lb[i]; fk[n] = lk[i]; n++;
    end
    chk(n == exp_n, {req, " length"}, n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++)
      chk(fb[i] == eb[i] && fk[i] == ek[i], req, {fk[i], fb[i]}, {ek[i], eb[i]});
    for (int i = 0; i + 1 < log_n; i++)
      if (lk[i] && lb[i] == 8'hFC)
        chk(!lk[i+1] && lb[i+1] == 8'hE9, "R8 after start comma", {lk[i+1], lb[i+1]}, 8'hE9);
  endtask

  task automatic send_hdr(input logic [3:0] t, input logic [7:0] b, input bit nohit);
    @(negedge clk); hdr_valid = 1; hdr_trig = t; hdr_bcid = b; hdr_nohit = nohit;
    #1; while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk); hdr_valid = 0;
  endtask
  task automatic send_hit(input logic [6:0] c, input logic [8:0] r, input logic [3:0] tt,
                          input logic [3:0] tb, input bit last);
    @(negedge clk); hit_valid = 1; hit_col = c; hit_row = r; hit_tot_top = tt; hit_tot_bot = tb; hit_last = last;
    #1; while (!hit_ready) begin @(negedge clk); #1; end
    @(negedge clk); hit_valid = 0;
  endtask
  task automatic send_rb(input bit vo, input bit ty, input logic [14:0] a, input logic [15:0] v);
    @(negedge clk); rb_valid = 1; rb_vonly = vo; rb_type = ty; rb_addr = a; rb_value = v;
    #1; while (!rb_ready) begin @(negedge clk); #1; end
    @(negedge clk); rb_valid = 0;
  endtask
  task automatic send_svc(input logic [15:0] m);
    @(negedge clk); svc_valid = 1; svc_msg = m;
    #1; while (!svc_ready) begin @(negedge clk); #1; end
    @(negedge clk); svc_valid = 0;
  endtask

  function automatic logic [23:0] hdr_r(input logic [3:0] t, input logic [7:0] b);
    return {5'b11101, 3'b001, 4'b0000, t, b};
  endfunction
  function automatic logic [23:0] hit_r(input logic [6:0] c, input logic [8:0] r,
                                        input logic [3:0] tt, input logic [3:0] tb);
    return {c, r, tt, tb};
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_byte == 8'h3C && out_k, "R1 idle comma", {out_k, out_byte}, 9'h13C);
    chk(!hdr_ready && !hit_ready && !rb_ready && !svc_ready, "R1 readies low",
        {hdr_ready, hit_ready, rb_ready, svc_ready}, 0);
  endtask

  task automatic t_frame;
    bit gap = 0; bit seen_hdr = 0;
    start_log;
    send_hdr(4'h5, 8'h3A, 0);
    repeat (10) @(negedge clk);
    send_hit(7'd1, 9'd336, 4'hA, 4'h3, 0);
    send_hit(7'd80, 9'd1, 4'hF, 4'h0, 1);
    push_k(8'hFC); push_rec(hdr_r(4'h5, 8'h3A));
    push_rec(hit_r(7'd1, 9'd336, 4'hA, 4'h3)); push_rec(hit_r(7'd80, 9'd1, 4'hF, 4'h0));
    push_k(8'hBC);
    compare("R3 R4 R2 frame with two hits", 0);
    for (int i = 0; i < log_n; i++) begin
      if (!lk[i] && lb[i] == 8'h05) seen_hdr = 1;
      if (seen_hdr && lk[i] && lb[i] == 8'h3C && !gap) gap = 1;
      if (!lk[i] && lb[i] == 8'h03) break;
    end
    chk(gap, "R3 idle filler inside stalled frame", gap, 1);
  endtask

  task automatic t_empty_event;
    start_log;
    send_hdr(4'hC, 8'hFF, 1);
    push_k(8'hFC); push_rec(hdr_r(4'hC, 8'hFF)); push_k(8'hBC);
    compare("R3 event without hits", 0);
  endtask

  task automatic t_readback;
    int f = -1;
    start_log;
    send_rb(0, 1, 15'h1234, 16'hBEEF);
    push_rec({5'b11101, 3'b010, 1'b1, 15'h1234}); push_rec({5'b11101, 3'b100, 16'hBEEF});
    compare("R5 address then value", 0);
    for (int i = 0; i < log_n; i++) if (!lk[i]) begin f = i; break; end
    chk(f >= 0 && f + 5 < log_n && !lk[f+3] && lb[f+3] == 8'hEC, "R5 value record adjacent",
        (f >= 0) ? lb[f+3] : 0, 8'hEC);
    start_log;
    send_rb(1, 0, 15'h7FFF, 16'h0102);
    push_rec({5'b11101, 3'b100, 16'h0102});
    compare("R5 value only", 0);
  endtask

  task automatic t_service;
    start_log;
    fork
      begin send_hdr(4'h1, 8'h22, 0); send_hit(7'd40, 9'd100, 4'h6, 4'h7, 1); end
      begin send_svc(16'hC0DE); send_svc(16'hD00D); end
    join
    push_k(8'hFC); push_rec(hdr_r(4'h1, 8'h22)); push_rec({5'b11101, 3'b111, 16'hC0DE});
    push_rec(hit_r(7'd40, 9'd100, 4'h6, 4'h7)); push_k(8'hBC);
    push_rec({5'b11101, 3'b111, 16'hD00D});
    compare("R6 one service per frame", 0);
  endtask

  task automatic t_priority;
    start_log;
    fork
      begin send_hdr(4'h9, 8'h10, 0); repeat (6) @(negedge clk); send_hit(7'd2, 9'd3, 4'h1, 4'h2, 1); end
      send_rb(0, 0, 15'h0042, 16'h1357);
    join
    push_k(8'hFC); push_rec(hdr_r(4'h9, 8'h10)); push_rec(hit_r(7'd2, 9'd3, 4'h1, 4'h2));
    push_k(8'hBC);
    push_rec({5'b11101, 3'b010, 1'b0, 15'h0042}); push_rec({5'b11101, 3'b100, 16'h1357});
    compare("R7 header before read-back, no interleave", 0);
  endtask

  task automatic t_bypass;
    bool_t: begin end
    enc_en = 0; fill_byte = 8'hA5;
    repeat (8) @(negedge clk);
    start_log;
    send_hdr(4'h2, 8'h07, 0);
    send_hit(7'd17, 9'd200, 4'h9, 4'h8, 1);
    push_rec(hdr_r(4'h2, 8'h07)); push_rec(hit_r(7'd17, 9'd200, 4'h9, 4'h8));
    compare("R9 bypass stream", 1);
    begin
      int kc = 0;
      for (int i = 0; i < log_n; i++) if (lk[i]) kc++;
      chk(kc == 0, "R9 no control flag in bypass", kc, 0);
      chk(log_n > 6 && lb[log_n-1] == 8'hA5 && lb[log_n-6] == 8'hA5, "R9 fill bytes when idle",
          lb[log_n-1], 8'hA5);
    end
    enc_en = 1;
    repeat (8) @(negedge clk);
    chk(out_k && out_byte == 8'h3C, "R9 encoding restored", {out_k, out_byte}, 9'h13C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_frame;
    t_empty_event;
    t_readback;
    t_service;
    t_priority;
    t_bypass;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule